// File: doc/BRIEF.md
# Vertical Scan Line Counter

This block counts scan lines for the vertical half of a display timing generator. Software programs a small set of byte-wide control registers: it writes a data byte together with an index. The block combines a low byte and a few high bits taken from other registers into two limits. The first is the frame length, programmed as the number of lines minus two. The second is the line on which vertical sync begins. A mode bit decides how wide both limits are and where their high bits come from. Legacy mode uses 10-bit limits whose two high bits sit in a shared overflow byte. Extended mode uses 12-bit limits whose four high bits come from dedicated extension registers.

An external horizontal section pulses `line_tick_i` once at the end of each scan line. On that pulse the counter moves to the next line, or goes back to line 0 once the frame is complete. The vertical sync output is recomputed on the same pulse. Active display always starts on line 0. A protection input stops software from changing the frame length.

Top module: `vscan_ctr`

## Requirements
- R1: After reset, `line_o` is 0, `vsync_o` is at its inactive level, and every register reads 00h.
- R2: Each register reads back, at its own index, the last value written to it. The indexes are 06h, 07h, 10h, 30h, 32h and 80h. Any other index reads 00h.
- R3: With bit 0 of index 80h clear (legacy mode), the frame length value T is formed as follows. Bit 9 is bit 5 of index 07h. Bit 8 is bit 0 of index 07h. Bits 7:0 are index 06h. The counter goes back to 0 on the tick after it reaches T+1, so a frame has T+2 lines.
- R4: With bit 0 of index 80h set (extended mode), bits 11:8 of T come from bits 3:0 of index 30h and bits 7:0 from index 06h. Bits 5 and 0 of index 07h have no effect in this mode.
- R5: In legacy mode the sync start S is formed as follows. Bit 9 is bit 7 of index 07h. Bit 8 is bit 2 of index 07h. Bits 7:0 are index 10h. With the default parameters, `vsync_o` is high exactly while `line_o` is S or S+1.
- R6: In extended mode, bits 11:8 of S come from bits 3:0 of index 32h and bits 7:0 from index 10h. Bits 7 and 2 of index 07h have no effect in this mode.
- R7: `line_o` and `vsync_o` change only in the cycle after `line_tick_i` is high. Register writes alone never move them.
- R8: While `prot_i` is high, writes to index 06h are dropped. A write to index 07h then changes only bit 4. Other registers stay writable.
- R9: A register write made before a tick is used by the limit comparison on that tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| idx_i | input | 8 | Write index |
| wdata_i | input | 8 | Write data |
| prot_i | input | 1 | Blocks writes to the frame length bits |
| rd_idx_i | input | 8 | Read index |
| rdata_o | output | 8 | Read data for `rd_idx_i`, combinational |
| line_tick_i | input | 1 | One-cycle end-of-line strobe |
| line_o | output | 13 | Current scan line |
| vsync_o | output | 1 | Vertical sync |

## Verification
Written registers, `line_o` and `vsync_o` are registered. Each of them shows its new value after exactly one rising edge following the write or tick strobe. Read data is combinational, so it is valid within the same cycle as `rd_idx_i`. The bench changes every input on the falling edge. It samples outputs on the next falling edge, or 1 ns after setting the read index. Each tick therefore yields exactly one new line value to compare against a line model in the bench that applies T and S.

// File: rtl/vscan_pkg.sv
`timescale 1ns/1ps
package vscan_pkg;
  localparam int REG_W = 8;
  localparam int LEG_W = 10;
  localparam int EXT_W = 12;
  localparam int CNT_W = EXT_W + 1;

  localparam logic [REG_W-1:0] IDX_VT   = 8'h06;
  localparam logic [REG_W-1:0] IDX_OVF  = 8'h07;
  localparam logic [REG_W-1:0] IDX_VS   = 8'h10;
  localparam logic [REG_W-1:0] IDX_XVT  = 8'h30;
  localparam logic [REG_W-1:0] IDX_XVS  = 8'h32;
  localparam logic [REG_W-1:0] IDX_MODE = 8'h80;

  // overflow byte bits that stay writable under protection
  localparam logic [REG_W-1:0] OVF_FREE = 8'h10;

  typedef struct packed {
    logic [REG_W-1:0] vt_lo;
    logic [REG_W-1:0] ovf;
    logic [REG_W-1:0] vs_lo;
    logic [REG_W-1:0] xvt;
    logic [REG_W-1:0] xvs;
    logic [REG_W-1:0] mode;
  } vreg_t;
endpackage

// File: rtl/vscan_regs.sv
`timescale 1ns/1ps
module vscan_regs
  import vscan_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] idx_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             prot_i,
  input  logic [REG_W-1:0] rd_idx_i,
  output logic [REG_W-1:0] rdata_o,
  output vreg_t            regs_o
);
  vreg_t regs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      regs_q <= '0;
    end else if (wr_en_i) begin
      case (idx_i)
        IDX_VT:   if (!prot_i) regs_q.vt_lo <= wdata_i;
        IDX_OVF:  begin
          if (prot_i)
            regs_q.ovf <= (regs_q.ovf & ~OVF_FREE) | (wdata_i & OVF_FREE);
          else
            regs_q.ovf <= wdata_i;
        end
        IDX_VS:   regs_q.vs_lo <= wdata_i;
        IDX_XVT:  regs_q.xvt   <= wdata_i;
        IDX_XVS:  regs_q.xvs   <= wdata_i;
        IDX_MODE: regs_q.mode  <= wdata_i;
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (rd_idx_i)
      IDX_VT:   rdata_o = regs_q.vt_lo;
      IDX_OVF:  rdata_o = regs_q.ovf;
      IDX_VS:   rdata_o = regs_q.vs_lo;
      IDX_XVT:  rdata_o = regs_q.xvt;
      IDX_XVS:  rdata_o = regs_q.xvs;
      IDX_MODE: rdata_o = regs_q.mode;
      default:  rdata_o = '0;
    endcase
  end

  assign regs_o = regs_q;
endmodule

// File: rtl/vscan_limit.sv
`timescale 1ns/1ps
module vscan_limit
  import vscan_pkg::*;
#(
  parameter int LO_W  = REG_W,
  parameter int LEG_H = LEG_W - REG_W,
  parameter int EXT_H = EXT_W - REG_W
) (
  input  logic [LO_W-1:0]      lo_i,
  input  logic [LEG_H-1:0]     leg_hi_i,
  input  logic [EXT_H-1:0]     ext_hi_i,
  input  logic                 ext_i,
  output logic [LO_W+EXT_H-1:0] val_o
);
  localparam int PAD_W = EXT_H - LEG_H;

  always_comb begin
    if (ext_i) val_o = {ext_hi_i, lo_i};
    else       val_o = {{PAD_W{1'b0}}, leg_hi_i, lo_i};
  end
endmodule

// File: rtl/vscan_counter.sv
`timescale 1ns/1ps
module vscan_counter
  import vscan_pkg::*;
#(
  parameter int   VAL_W       = EXT_W,
  parameter int   LINE_W      = CNT_W,
  parameter int   VS_LINES    = 2,
  parameter logic VS_ACT_HIGH = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [VAL_W-1:0]  total_i,
  input  logic [VAL_W-1:0]  sync_i,
  output logic [LINE_W-1:0] line_o,
  output logic              vsync_o
);
  localparam int          SUM_W = LINE_W + 1;
  localparam logic [SUM_W-1:0] VS_N = SUM_W'(VS_LINES);

  logic [LINE_W-1:0] line_q, line_nxt, last_line;
  logic [SUM_W-1:0]  vs_beg, vs_end, nxt_w;
  logic              in_sync, vsync_q;

  // frame holds total+2 lines: last index is total+1
  assign last_line = LINE_W'(total_i) + LINE_W'(1);
  assign line_nxt  = (line_q >= last_line) ? '0 : line_q + LINE_W'(1);

  assign vs_beg  = SUM_W'(sync_i);
  assign vs_end  = vs_beg + VS_N;
  assign nxt_w   = SUM_W'(line_nxt);
  assign in_sync = (nxt_w >= vs_beg) && (nxt_w < vs_end);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q  <= '0;
      vsync_q <= ~VS_ACT_HIGH;
    end else if (tick_i) begin
      line_q  <= line_nxt;
      vsync_q <= in_sync ~^ VS_ACT_HIGH;
    end
  end

  assign line_o  = line_q;
  assign vsync_o = vsync_q;
endmodule

// File: rtl/vscan_ctr.sv
`timescale 1ns/1ps
module vscan_ctr
  import vscan_pkg::*;
#(
  parameter int   VS_LINES    = 2,
  parameter logic VS_ACT_HIGH = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [7:0]       idx_i,
  input  logic [7:0]       wdata_i,
  input  logic             prot_i,
  input  logic [7:0]       rd_idx_i,
  output logic [7:0]       rdata_o,
  input  logic             line_tick_i,
  output logic [CNT_W-1:0] line_o,
  output logic             vsync_o
);
  localparam int LEG_H = LEG_W - REG_W;
  localparam int EXT_H = EXT_W - REG_W;

  vreg_t             regs;
  logic [EXT_W-1:0]  vt_val, vs_val;
  logic [REG_W-1:0]  vt_lo_q, ovf_q;
  logic              ext_mode;

  vscan_regs u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .idx_i    (idx_i),
    .wdata_i  (wdata_i),
    .prot_i   (prot_i),
    .rd_idx_i (rd_idx_i),
    .rdata_o  (rdata_o),
    .regs_o   (regs)
  );

  assign ext_mode = regs.mode[0];
  assign vt_lo_q  = regs.vt_lo;
  assign ovf_q    = regs.ovf;

  vscan_limit #(.LO_W(REG_W), .LEG_H(LEG_H), .EXT_H(EXT_H)) u_vt (
    .lo_i     (regs.vt_lo),
    .leg_hi_i ({regs.ovf[5], regs.ovf[0]}),
    .ext_hi_i (regs.xvt[EXT_H-1:0]),
    .ext_i    (ext_mode),
    .val_o    (vt_val)
  );

  vscan_limit #(.LO_W(REG_W), .LEG_H(LEG_H), .EXT_H(EXT_H)) u_vs (
    .lo_i     (regs.vs_lo),
    .leg_hi_i ({regs.ovf[7], regs.ovf[2]}),
    .ext_hi_i (regs.xvs[EXT_H-1:0]),
    .ext_i    (ext_mode),
    .val_o    (vs_val)
  );

  vscan_counter #(
    .VAL_W       (EXT_W),
    .LINE_W      (CNT_W),
    .VS_LINES    (VS_LINES),
    .VS_ACT_HIGH (VS_ACT_HIGH)
  ) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (line_tick_i),
    .total_i (vt_val),
    .sync_i  (vs_val),
    .line_o  (line_o),
    .vsync_o (vsync_o)
  );
endmodule

// File: rtl/vscan_ctr_chk.sv
`timescale 1ns/1ps
module vscan_ctr_chk
  import vscan_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [7:0]       idx_i,
  input logic             prot_i,
  input logic             line_tick_i,
  input logic [CNT_W-1:0] line_o,
  input logic             vsync_o,
  input logic [EXT_W-1:0] vt_val,
  input logic [REG_W-1:0] vt_lo_q,
  input logic [REG_W-1:0] ovf_q
);
  // R7
  line_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_tick_i |=> $stable(line_o));

  // R7
  vsync_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_tick_i |=> $stable(vsync_o));

  // R3
  line_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_tick_i |=> (line_o == $past(line_o) + CNT_W'(1)) || (line_o == '0));

  // R3
  frame_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_tick_i && (line_o >= CNT_W'(vt_val) + CNT_W'(1))) |=> (line_o == '0));

  // R8
  prot_vt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && prot_i && idx_i == IDX_VT) |=> $stable(vt_lo_q));

  // R8
  prot_ovf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && prot_i && idx_i == IDX_OVF) |=>
      ($stable(ovf_q[7:5]) && $stable(ovf_q[3:0])));
endmodule

bind vscan_ctr vscan_ctr_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .idx_i       (idx_i),
  .prot_i      (prot_i),
  .line_tick_i (line_tick_i),
  .line_o      (line_o),
  .vsync_o     (vsync_o),
  .vt_val      (vt_val),
  .vt_lo_q     (vt_lo_q),
  .ovf_q       (ovf_q)
);

// File: tb/sim_vscan_ctr.sv
`timescale 1ns/1ps
module sim_vscan_ctr;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [7:0]  idx_i = '0;
  logic [7:0]  wdata_i = '0;
  logic        prot_i = 1'b0;
  logic [7:0]  rd_idx_i = '0;
  logic [7:0]  rdata_o;
  logic        line_tick_i = 1'b0;
  logic [12:0] line_o;
  logic        vsync_o;

  int checks = 0;
  int errors = 0;
  int exp_line = 0;

  always #2.5 clk_i = ~clk_i;

  vscan_ctr u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .idx_i(idx_i),
    .wdata_i(wdata_i), .prot_i(prot_i), .rd_idx_i(rd_idx_i), .rdata_o(rdata_o),
    .line_tick_i(line_tick_i), .line_o(line_o), .vsync_o(vsync_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i) rst_ni = 1'b0;
    @(negedge clk_i) rst_ni = 1'b1;
    exp_line = 0;
  endtask

  task automatic wr(input logic [7:0] idx, input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; idx_i = idx; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] idx, input int exp);
    rd_idx_i = idx;
    #1;
    chk(req, int'(rdata_o), exp);
  endtask

  task automatic tick();
    @(negedge clk_i) line_tick_i = 1'b1;
    @(negedge clk_i) line_tick_i = 1'b0;
  endtask

  // advance n lines against a model of frame total t and sync start s
  task automatic run(input string req, input int n, input int t, input int s,
                     input bit vs_on, input bit each);
    for (int i = 0; i < n; i++) begin
      tick();
      exp_line = (exp_line >= t + 1) ? 0 : exp_line + 1;
      if (each || i == n - 1) begin
        chk(req, int'(line_o), exp_line);
        if (vs_on)
          chk(req, int'(vsync_o), int'(exp_line >= s && exp_line < s + 2));
      end
    end
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1", int'(line_o), 0);
    chk("R1", int'(vsync_o), 0);
    rd_chk("R1", 8'h06, 0); rd_chk("R1", 8'h07, 0); rd_chk("R1", 8'h10, 0);
    rd_chk("R1", 8'h30, 0); rd_chk("R1", 8'h32, 0); rd_chk("R1", 8'h80, 0);
  endtask

  task automatic t_readback();
    do_reset();
    wr(8'h06, 8'hA5); wr(8'h07, 8'hFF); wr(8'h10, 8'h3C);
    wr(8'h30, 8'h9E); wr(8'h32, 8'h61); wr(8'h80, 8'h02);
    wr(8'h55, 8'h77);
    rd_chk("R2", 8'h06, 'hA5); rd_chk("R2", 8'h07, 'hFF);
    rd_chk("R2", 8'h10, 'h3C); rd_chk("R2", 8'h30, 'h9E);
    rd_chk("R2", 8'h32, 'h61); rd_chk("R2", 8'h80, 'h02);
    rd_chk("R2", 8'h55, 0);
  endtask

  task automatic t_legacy_total();
    do_reset();
    wr(8'h06, 8'h03);
    run("R3", 11, 3, 4095, 1'b0, 1'b1);
    do_reset();
    wr(8'h06, 8'h03); wr(8'h07, 8'h01);
    run("R3", 260, 259, 4095, 1'b0, 1'b0);
    run("R3", 1, 259, 4095, 1'b0, 1'b1);
    do_reset();
    wr(8'h06, 8'h03); wr(8'h07, 8'h20);
    run("R3", 516, 515, 4095, 1'b0, 1'b0);
    run("R3", 1, 515, 4095, 1'b0, 1'b1);
  endtask

  task automatic t_ext_total();
    do_reset();
    wr(8'h80, 8'h01); wr(8'h30, 8'h01); wr(8'h06, 8'h00); wr(8'h07, 8'h21);
    run("R4", 257, 256, 4095, 1'b0, 1'b0);
    run("R4", 2, 256, 4095, 1'b0, 1'b1);
  endtask

  task automatic t_sync_legacy();
    do_reset();
    wr(8'h06, 8'h09); wr(8'h10, 8'h04);
    run("R5", 14, 9, 4, 1'b1, 1'b1);
    do_reset();
    wr(8'h06, 8'h09); wr(8'h10, 8'h04); wr(8'h07, 8'h05);
    run("R5", 258, 265, 260, 1'b1, 1'b0);
    run("R5", 5, 265, 260, 1'b1, 1'b1);
  endtask

  task automatic t_sync_ext();
    do_reset();
    wr(8'h80, 8'h01); wr(8'h30, 8'h01); wr(8'h06, 8'h10);
    wr(8'h32, 8'h01); wr(8'h10, 8'h02); wr(8'h07, 8'h84);
    run("R6", 256, 272, 258, 1'b1, 1'b0);
    run("R6", 5, 272, 258, 1'b1, 1'b1);
  endtask

  task automatic t_tick_only();
    do_reset();
    wr(8'h06, 8'h09); wr(8'h10, 8'h00);
    repeat (20) @(negedge clk_i);
    chk("R7", int'(line_o), 0);
    chk("R7", int'(vsync_o), 0);
    run("R7", 1, 9, 0, 1'b1, 1'b1);
    wr(8'h10, 8'h01);
    repeat (5) @(negedge clk_i);
    chk("R7", int'(line_o), 1);
    chk("R7", int'(vsync_o), 1);
  endtask

  task automatic t_protect();
    do_reset();
    prot_i = 1'b1;
    wr(8'h06, 8'h55); wr(8'h07, 8'hFF); wr(8'h10, 8'h77); wr(8'h30, 8'h0A);
    rd_chk("R8", 8'h06, 0);
    rd_chk("R8", 8'h07, 'h10);
    rd_chk("R8", 8'h10, 'h77);
    rd_chk("R8", 8'h30, 'h0A);
    run("R8", 3, 0, 4095, 1'b0, 1'b1);
    prot_i = 1'b0;
    wr(8'h06, 8'h55);
    rd_chk("R8", 8'h06, 'h55);
  endtask

  task automatic t_next_tick();
    do_reset();
    wr(8'h06, 8'h09);
    run("R9", 3, 9, 4095, 1'b0, 1'b1);
    wr(8'h06, 8'h02);
    chk("R9", int'(line_o), 3);
    run("R9", 1, 2, 4095, 1'b0, 1'b1);
    run("R9", 3, 2, 4095, 1'b0, 1'b1);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_readback();
    t_legacy_total();
    t_ext_total();
    t_sync_legacy();
    t_sync_ext();
    t_tick_only();
    t_protect();
    t_next_tick();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule